// File: doc/BRIEF.md
# Event State Load Decoder

This block holds a two-bit event state (P and Q bits) for each of a fixed number of event-queue entries and exposes it through a load-only memory-mapped window. Each entry owns two consecutive pages: the even page reaches the notification state and the odd page reaches the escalation state. The low twelve bits of a load address select the operation: an end-of-interrupt, a plain read of the state, or a forced set of the state to a chosen value. Every accepted load returns a 64-bit result one cycle later. State is written back only when it actually changes.

A separate notify input lets upstream logic report an event for an entry. Unless the entry is marked for unconditional forwarding, the notification state runs through trigger semantics, which coalesces repeated events: the event is forwarded only on the first trigger from the idle state. Per-entry valid and unconditional-forwarding flags are loaded through a small configuration port. Loads that fail any check (wrong size, wrong byte order, a store, an entry beyond the table or an entry not yet valid) come back with an error flag and all-ones data, and change nothing.

Top module: `evstate_load_decoder`

## Requirements
- R1: After reset every state pair holds 01 (P is bit 1, Q is bit 0) and every valid and unconditional-forwarding flag is clear.
- R2: The entry index is the request address shifted right by PAGE_SHIFT+1; address bit PAGE_SHIFT selects the notification state (0) or the escalation state (1).
- R3: A load whose offset bits 11:10 are 00 or 01 performs an end-of-interrupt on the selected state: 11 becomes 10 and returns 1; 10 becomes 00 and returns 0; 00 and 01 stay and return 0.
- R4: A load whose offset bits 11:10 are 10 returns the selected state in data bits 1:0, zeros above, and changes no state.
- R5: A load whose offset bits 11:10 are 11 sets the selected state to offset bits 9:8 and returns the previous state in data bits 1:0.
- R6: A load to an index at or beyond N_ENTRIES, or to an entry whose valid flag is clear, returns the error flag with all-ones data and changes no state.
- R7: A store, an access whose size is not 8 bytes, or an access not flagged big-endian returns the error flag with all-ones data and changes no state.
- R8: Every request receives exactly one response, with rsp_valid high in the cycle after req_valid; rsp_valid is never high otherwise.
- R9: A notify for an entry with unconditional forwarding clear applies the trigger to its notification state (00 to 10, 10 and 11 to 11, 01 unchanged); ntf_fwd pulses in the next cycle only when the state was 00.
- R10: A notify for an entry with unconditional forwarding set always pulses ntf_fwd in the next cycle and leaves its state unchanged.
- R11: When a load and a notify touch the same notification state in one cycle, the load is applied first and the trigger acts on its result; the load response reflects the load alone.
- R12: cfg_we writes the valid and unconditional-forwarding flags of entry cfg_idx; the new flags govern requests from the next cycle on.
- R13: PAGE_SHIFT must be 12 or 16, N_ENTRIES nonzero, and ADDR_W wide enough for every entry; other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | Request is a store |
| req_size | input | 4 | Access size in bytes |
| req_big_endian | input | 1 | Access uses big-endian byte order |
| req_addr | input | ADDR_W | Byte address within the window |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request rejected |
| rsp_data | output | 64 | Load result, all ones on error |
| ntf_valid | input | 1 | Event notify strobe |
| ntf_idx | input | IDX_W | Entry receiving the event |
| ntf_fwd | output | 1 | Event forwarded, one cycle after notify |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Entry being configured |
| cfg_valid | input | 1 | New valid flag |
| cfg_ucond | input | 1 | New unconditional-forwarding flag |

## Verification
Both results of this block are due exactly one clock edge after their stimulus: rsp_valid, rsp_err and rsp_data after the request edge, and ntf_fwd after the notify edge, with the state update landing on that same edge. The bench drives each stimulus on a falling edge, waits for the next rising edge and samples one time unit later, comparing against a model that is advanced only after the comparison, so the model's pre-edge state forms the expectation. State changes are then observed only through later read loads, never through internal signals.

// File: rtl/evs_pkg.sv
package evs_pkg;

   typedef enum logic [1:0] {
      EVS_OP_EOI = 2'd0,
      EVS_OP_GET = 2'd1,
      EVS_OP_SET = 2'd2
   } evs_op_e;

   localparam logic [1:0] EVS_PQ_IDLE = 2'b00;
   localparam logic [1:0] EVS_PQ_OFF  = 2'b01;
   localparam logic [1:0] EVS_PQ_PEND = 2'b10;
   localparam logic [1:0] EVS_PQ_QUE  = 2'b11;

   // {fire, next state}
   function automatic logic [2:0] evs_trigger(input logic [1:0] pq);
      case (pq)
         EVS_PQ_IDLE: return {1'b1, EVS_PQ_PEND};
         EVS_PQ_OFF:  return {1'b0, EVS_PQ_OFF};
         default:     return {1'b0, EVS_PQ_QUE};
      endcase
   endfunction

   // {returned bit, next state}
   function automatic logic [2:0] evs_eoi(input logic [1:0] pq);
      case (pq)
         EVS_PQ_QUE:  return {1'b1, EVS_PQ_PEND};
         EVS_PQ_PEND: return {1'b0, EVS_PQ_IDLE};
         default:     return {1'b0, pq};
      endcase
   endfunction

endpackage

// File: rtl/evs_load_decode.sv
module evs_load_decode
   import evs_pkg::*;
#(
   parameter int N_ENTRIES  = 8,
   parameter int PAGE_SHIFT = 12,
   parameter int ADDR_W     = 20,
   parameter int IDX_W      = 3
) (
   input  logic              req_write,
   input  logic [3:0]        req_size,
   input  logic              req_big_endian,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [IDX_W-1:0]  dec_idx,
   output logic              dec_in_range,
   output logic              dec_esc,
   output logic              dec_form_ok,
   output evs_op_e           dec_op,
   output logic [1:0]        dec_set_val
);
   localparam int XW = ADDR_W - PAGE_SHIFT - 1;

   logic [XW-1:0] wide_idx;
   logic [11:0]   page_off;

   always_comb begin
      wide_idx     = req_addr[ADDR_W-1:PAGE_SHIFT+1];
      page_off     = req_addr[11:0];
      dec_idx      = wide_idx[IDX_W-1:0];
      dec_in_range = (32'(wide_idx) < N_ENTRIES);
      dec_esc      = req_addr[PAGE_SHIFT];
      dec_form_ok  = !req_write && (req_size == 4'd8) && req_big_endian;
      dec_set_val  = page_off[9:8];
      case (page_off[11:10])
         2'b10:   dec_op = EVS_OP_GET;
         2'b11:   dec_op = EVS_OP_SET;
         default: dec_op = EVS_OP_EOI;
      endcase
   end
endmodule

// File: rtl/evs_pq_bank.sv
module evs_pq_bank #(
   parameter int N_ENTRIES = 8,
   parameter int IDX_W     = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_we,
   input  logic [IDX_W-1:0]       ld_idx,
   input  logic                   ld_esc,
   input  logic [1:0]             ld_val,
   input  logic                   tr_we,
   input  logic [IDX_W-1:0]       tr_idx,
   input  logic [1:0]             tr_val,
   input  logic                   cfg_we,
   input  logic [IDX_W-1:0]       cfg_idx,
   input  logic                   cfg_valid,
   input  logic                   cfg_ucond,
   output logic [2*N_ENTRIES-1:0] pq_ntf_flat,
   output logic [2*N_ENTRIES-1:0] pq_esc_flat,
   output logic [N_ENTRIES-1:0]   valid_vec,
   output logic [N_ENTRIES-1:0]   ucond_vec
);
   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
      logic hit_ld, hit_tr, hit_cfg;
      assign hit_ld  = ld_we  && (32'(ld_idx)  == i);
      assign hit_tr  = tr_we  && (32'(tr_idx)  == i);
      assign hit_cfg = cfg_we && (32'(cfg_idx) == i);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pq_ntf_flat[2*i +: 2] <= 2'b01;
            pq_esc_flat[2*i +: 2] <= 2'b01;
            valid_vec[i]          <= 1'b0;
            ucond_vec[i]          <= 1'b0;
         end else begin
            // trigger result already folds in a same-entry load
            if (hit_tr)
               pq_ntf_flat[2*i +: 2] <= tr_val;
            else if (hit_ld && !ld_esc)
               pq_ntf_flat[2*i +: 2] <= ld_val;
            if (hit_ld && ld_esc)
               pq_esc_flat[2*i +: 2] <= ld_val;
            if (hit_cfg) begin
               valid_vec[i] <= cfg_valid;
               ucond_vec[i] <= cfg_ucond;
            end
         end
      end
   end
endmodule

// File: rtl/evstate_load_decoder.sv
module evstate_load_decoder
   import evs_pkg::*;
#(
   parameter int N_ENTRIES  = 8,
   parameter int PAGE_SHIFT = 12,
   parameter int ADDR_W     = 20,
   localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [3:0]        req_size,
   input  logic              req_big_endian,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [63:0]       rsp_data,
   input  logic              ntf_valid,
   input  logic [IDX_W-1:0]  ntf_idx,
   output logic              ntf_fwd,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_valid,
   input  logic              cfg_ucond
);
   // R13: elaboration-time parameter checks
   if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
      $error("PAGE_SHIFT must be 12 or 16");
   end
   if (N_ENTRIES < 1) begin : g_bad_count
      $error("N_ENTRIES must be nonzero");
   end
   if (ADDR_W < PAGE_SHIFT + 1 + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for N_ENTRIES page pairs");
   end

   logic [IDX_W-1:0]       d_idx;
   logic                   d_in_range, d_esc, d_form_ok;
   evs_op_e                d_op;
   logic [1:0]             d_set_val;
   logic [2*N_ENTRIES-1:0] pq_ntf_flat, pq_esc_flat;
   logic [N_ENTRIES-1:0]   valid_vec, ucond_vec;

   evs_load_decode #(
      .N_ENTRIES(N_ENTRIES), .PAGE_SHIFT(PAGE_SHIFT),
      .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) i_dec (
      .req_write(req_write), .req_size(req_size),
      .req_big_endian(req_big_endian), .req_addr(req_addr),
      .dec_idx(d_idx), .dec_in_range(d_in_range), .dec_esc(d_esc),
      .dec_form_ok(d_form_ok), .dec_op(d_op), .dec_set_val(d_set_val)
   );

   logic        ld_ok, ld_we, tr_we, ntf_hit, fire, ucond_sel;
   logic [1:0]  cur_pq, nxt_pq, tr_base, tr_nxt, ntf_stored;
   logic [2:0]  eoi_res, trig_res;
   logic [63:0] ld_data;

   always_comb begin
      ld_ok   = 1'b0;
      cur_pq  = 2'b01;
      if (d_in_range) begin
         ld_ok  = req_valid && d_form_ok && valid_vec[d_idx];
         cur_pq = d_esc ? pq_esc_flat[2*d_idx +: 2] : pq_ntf_flat[2*d_idx +: 2];
      end
      eoi_res = evs_eoi(cur_pq);
      case (d_op)
         EVS_OP_GET: begin nxt_pq = cur_pq;       ld_data = {62'd0, cur_pq}; end
         EVS_OP_SET: begin nxt_pq = d_set_val;    ld_data = {62'd0, cur_pq}; end
         default:    begin nxt_pq = eoi_res[1:0]; ld_data = {63'd0, eoi_res[2]}; end
      endcase
      ld_we = ld_ok && (nxt_pq != cur_pq);

      ntf_hit    = ntf_valid && (32'(ntf_idx) < N_ENTRIES);
      ntf_stored = 2'b01;
      ucond_sel  = 1'b0;
      if (32'(ntf_idx) < N_ENTRIES) begin
         ntf_stored = pq_ntf_flat[2*ntf_idx +: 2];
         ucond_sel  = ucond_vec[ntf_idx];
      end
      tr_base  = (ld_ok && !d_esc && (d_idx == ntf_idx)) ? nxt_pq : ntf_stored;
      trig_res = evs_trigger(tr_base);
      tr_nxt   = trig_res[1:0];
      fire     = trig_res[2];
      tr_we    = ntf_hit && !ucond_sel && (tr_nxt != tr_base);
   end

   evs_pq_bank #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .ld_we(ld_we), .ld_idx(d_idx), .ld_esc(d_esc), .ld_val(nxt_pq),
      .tr_we(tr_we), .tr_idx(ntf_idx), .tr_val(tr_nxt),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_ucond(cfg_ucond),
      .pq_ntf_flat(pq_ntf_flat), .pq_esc_flat(pq_esc_flat),
      .valid_vec(valid_vec), .ucond_vec(ucond_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         ntf_fwd   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !ld_ok;
         rsp_data  <= ld_ok ? ld_data : '1;
         ntf_fwd   <= ntf_hit && (ucond_sel || fire);
      end
   end

   // R8: one response per request, one cycle later
   p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R6 / R7: error responses carry all ones
   p_err_all_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == '1));
   // R4: accepted loads return only two meaningful bits
   p_ok_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_data[63:2] == '0));
   // R7: stores leave every state untouched
   p_store_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !ntf_valid) |=>
      (pq_ntf_flat == $past(pq_ntf_flat) && pq_esc_flat == $past(pq_esc_flat)));
   // R4: reads have no side effect
   p_get_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && d_op == EVS_OP_GET && !ntf_valid) |=>
      (pq_ntf_flat == $past(pq_ntf_flat) && pq_esc_flat == $past(pq_esc_flat)));
   // R9: forwarding only follows a notify
   p_fwd_needs_notify_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_fwd |-> $past(ntf_valid));
endmodule

// File: tb/test_evstate_load_decoder.sv
module test_evstate_load_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int PS = 12;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 0, req_write = 0, req_be = 1;
   logic [3:0]    req_size = 4'd8;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_err, ntf_fwd;
   logic [63:0]   rsp_data;
   logic          ntf_valid = 0, cfg_we = 0, cfg_valid = 0, cfg_ucond = 0;
   logic [2:0]    ntf_idx = '0, cfg_idx = '0;

   int checks = 0, fails = 0;

   logic [1:0] m_ntf [N];
   logic [1:0] m_esc [N];
   logic       m_valid [N];
   logic       m_ucond [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   evstate_load_decoder #(.N_ENTRIES(N), .PAGE_SHIFT(PS), .ADDR_W(AW)) i_evstate_load_decoder (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_big_endian(req_be), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .ntf_valid(ntf_valid), .ntf_idx(ntf_idx), .ntf_fwd(ntf_fwd),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_ucond(cfg_ucond)
   );

   function automatic logic [2:0] f_trig(input logic [1:0] pq);
      if (pq == 2'b00) return 3'b110;
      if (pq == 2'b01) return 3'b001;
      return 3'b011;
   endfunction

   function automatic logic [2:0] f_eoi(input logic [1:0] pq);
      if (pq == 2'b11) return 3'b110;
      if (pq == 2'b10) return 3'b000;
      return {1'b0, pq};
   endfunction

   function automatic logic [AW-1:0] mk_addr(input int idx, input bit esc, input logic [11:0] off);
      return AW'(idx) << (PS + 1) | AW'(esc) << PS | AW'(off);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus, model prediction and checking
   task automatic step(input bit rq, input bit wr, input logic [3:0] sz, input bit be,
                       input logic [AW-1:0] ad, input bit nv, input int ni,
                       input bit cw, input int ci, input bit cv, input bit cu,
                       input string tag);
      logic [1:0] n2 [N];
      logic [1:0] e2 [N];
      int xi, idx;
      bit fld, ok, fwd;
      logic [11:0] off;
      logic [1:0] cur, nxt;
      logic [2:0] r;
      logic [63:0] dat;
      @(negedge clk);
      req_valid = rq; req_write = wr; req_size = sz; req_be = be; req_addr = ad;
      ntf_valid = nv; ntf_idx = 3'(ni);
      cfg_we = cw; cfg_idx = 3'(ci); cfg_valid = cv; cfg_ucond = cu;
      n2 = m_ntf; e2 = m_esc;
      xi = int'(ad >> (PS + 1)); idx = xi % N; fld = ad[PS]; off = ad[11:0];
      ok = rq && !wr && sz == 4'd8 && be && xi < N && m_valid[idx];
      dat = '1;
      if (ok) begin
         cur = fld ? m_esc[idx] : m_ntf[idx];
         case (off[11:10])
            2'b10: begin nxt = cur; dat = {62'd0, cur}; end
            2'b11: begin nxt = off[9:8]; dat = {62'd0, cur}; end
            default: begin r = f_eoi(cur); nxt = r[1:0]; dat = {63'd0, r[2]}; end
         endcase
         if (fld) e2[idx] = nxt; else n2[idx] = nxt;
      end
      fwd = 0;
      if (nv) begin
         if (m_ucond[ni]) fwd = 1;
         else begin r = f_trig(n2[ni]); n2[ni] = r[1:0]; fwd = r[2]; end
      end
      @(posedge clk);
      #1;
      check({tag, " R8 rsp_valid"}, 64'(rsp_valid), 64'(rq));
      if (rq) begin
         check({tag, " rsp_err"}, 64'(rsp_err), 64'(!ok));
         check({tag, " rsp_data"}, rsp_data, dat);
      end
      check({tag, " ntf_fwd"}, 64'(ntf_fwd), 64'(fwd));
      m_ntf = n2; m_esc = e2;
      if (cw) begin m_valid[ci] = cv; m_ucond[ci] = cu; end
   endtask

   task automatic load(input int idx, input bit esc, input logic [11:0] off, input string tag);
      step(1, 0, 4'd8, 1, mk_addr(idx, esc, off), 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic notify(input int idx, input string tag);
      step(0, 0, 4'd8, 1, '0, 1, idx, 0, 0, 0, 0, tag);
   endtask

   task automatic config_entry(input int idx, input bit v, input bit u);
      step(0, 0, 4'd8, 1, '0, 0, 0, 1, idx, v, u, "R12 cfg");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'h5eed_1234);
      for (int i = 0; i < N; i++) begin
         m_ntf[i] = 2'b01; m_esc[i] = 2'b01; m_valid[i] = 0; m_ucond[i] = 0;
      end
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      check("R1 reset rsp_valid", 64'(rsp_valid), 0);
      check("R1 reset ntf_fwd", 64'(ntf_fwd), 0);

      // R1 / R6: nothing valid after reset
      load(0, 0, 12'h800, "R1 R6 invalid entry get");
      // R12: enable entries, then read reset state
      for (int i = 0; i < N; i++) config_entry(i, 1, 0);
      for (int i = 0; i < N; i++) begin
         load(i, 0, 12'h800, "R1 R2 ntf reset get");
         load(i, 1, 12'h800, "R1 R2 esc reset get");
      end
      // R5: set notification state of entry 3 to 00, escalation to 11
      load(3, 0, 12'hC00, "R5 set 00");
      load(3, 1, 12'hF00, "R5 set 11");
      load(3, 0, 12'h800, "R2 R4 get ntf");
      load(3, 1, 12'h800, "R2 R4 get esc");
      // R9: trigger coalescing
      notify(3, "R9 first trigger");
      notify(3, "R9 coalesced trigger");
      load(3, 0, 12'h900, "R9 R4 get after triggers");
      // R3: EOI sequence 11 -> 10 -> 00
      load(3, 0, 12'h000, "R3 eoi from 11");
      load(3, 0, 12'h7F8, "R3 eoi from 10");
      load(3, 0, 12'h400, "R3 eoi from 00");
      // R6: out-of-range index
      step(1, 0, 4'd8, 1, mk_addr(9, 0, 12'hC00), 0, 0, 0, 0, 0, 0, "R6 out of range");
      // R7: store, narrow, little-endian
      step(1, 1, 4'd8, 1, mk_addr(3, 0, 12'hD00), 0, 0, 0, 0, 0, 0, "R7 store");
      step(1, 0, 4'd4, 1, mk_addr(3, 0, 12'hD00), 0, 0, 0, 0, 0, 0, "R7 size");
      step(1, 0, 4'd8, 0, mk_addr(3, 0, 12'hD00), 0, 0, 0, 0, 0, 0, "R7 endian");
      load(3, 0, 12'h800, "R7 state kept");
      // R10: unconditional forwarding
      config_entry(5, 1, 1);
      notify(5, "R10 ucond notify");
      notify(5, "R10 ucond notify again");
      load(5, 0, 12'h800, "R10 state kept");
      // R11: load and notify on same entry in one cycle
      load(2, 0, 12'hF00, "R11 prep set 11");
      step(1, 0, 4'd8, 1, mk_addr(2, 0, 12'h000), 1, 2, 0, 0, 0, 0, "R11 eoi plus notify");
      load(2, 0, 12'h800, "R11 result get");
      // R12: disabling an entry
      config_entry(6, 0, 0);
      load(6, 1, 12'h800, "R12 R6 disabled entry");

      // constrained random mix
      for (int k = 0; k < 3000; k++) begin
         int pick, xi, ni;
         bit rq, wr, be, nv, cw, esc;
         logic [3:0] sz;
         logic [11:0] off;
         pick = $urandom_range(0, 99);
         rq   = pick < 75;
         wr   = $urandom_range(0, 99) < 5;
         sz   = ($urandom_range(0, 99) < 4) ? 4'd4 : 4'd8;
         be   = $urandom_range(0, 99) >= 3;
         xi   = $urandom_range(0, N + 1);
         esc  = 1'($urandom_range(0, 1));
         off  = 12'($urandom_range(0, 4095));
         nv   = $urandom_range(0, 99) < 40;
         ni   = $urandom_range(0, N - 1);
         cw   = $urandom_range(0, 99) < 4;
         step(rq, wr, sz, be, mk_addr(xi, esc, off), nv, ni,
              cw, $urandom_range(0, N - 1), $urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
              "R2 R3 R4 R5 R9 R11 random");
      end

      @(negedge clk);
      req_valid = 0; ntf_valid = 0; cfg_we = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule